// File: doc/BRIEF.md
# Byte-Serial CRC-16 Checksum Engine

This block computes the 16-bit CCITT checksum used to protect infrared serial frames. Software clears the engine through a control register, then writes the payload one byte per bus write into a data register. Each write folds the byte into the running checksum and advances a byte counter. Software reads the counter back from the control register and the finished checksum from a result register.

The bus is a simple 16-bit register port with a write strobe, a word address and a read path that is combinational from the selected address. Each byte completes in the clock edge that accepts its write, so a read in the following cycle already shows the new checksum and count. A fixed four-byte pattern with a known result lets software test the engine at start-up.

Top module: `sir_crc_engine`

## Requirements
- R1: After hardware reset (rst_n low) the count field reads 0 and the result register (address 2) reads 0x0000.
- R2: A write to the control register (address 0) with bit 15 set returns the checksum state to 0xFFFF and the count to 0, seen as count 0 and result 0x0000 on the next read.
- R3: Bits 15 to 12 of the control register always read 0; bit 15 clears itself and is never readable as 1.
- R4: A write to the data register (address 1) feeds only bits 7 to 0 as one byte; bits 15 to 8 of the write have no effect on the result.
- R5: The checksum uses the reflected polynomial 0x8408, bits in least-significant-first order, initial value 0xFFFF, and the result register shows the ones-complement of the running value.
- R6: Each data write increments the 12-bit count in bits 11 to 0 of the control register, and both the new count and the new result are readable in the cycle after the write.
- R7: After a clear, feeding 0xCC, 0xF5, 0xF1, 0xA7 gives a count of 4 and a result of 0x51DF.
- R8: The count stops at 0xFFF and does not wrap, while the checksum keeps absorbing further bytes.
- R9: A control write with bit 15 clear, or any write to the result register or to unmapped address 3, changes neither the count nor the result.
- R10: A read of unmapped address 3 returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 2 | Word address: 0 control, 1 data, 2 result |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
Every result is due exactly one clock edge after the write that causes it, because the checksum and the counter are single registers and the read path has no register. The bench drives a write on a falling edge, lets the next rising edge take it, and reads on the following falling edge, so every compare falls in the first cycle where the new value must be visible. Reads of the result and count are checked against a model in the bench that uses a byte-wide table-free formula, different from the bit loop in the design.

// File: rtl/sir_crc_pkg.sv
package sir_crc_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

  // One byte through the reflected CCITT register, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] state,
                                                     input logic [7:0] data);
    logic [CRC_W-1:0] s;
    s = state ^ {8'h00, data};
    for (int i = 0; i < 8; i++) begin
      if (s[0]) s = (s >> 1) ^ CRC_POLY_REFL;
      else      s = s >> 1;
    end
    return s;
  endfunction

endpackage

// File: rtl/sir_crc_bus_decode.sv
module sir_crc_bus_decode #(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 16,
  parameter int CLR_BIT   = 15,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 0,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 1
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              feed_evt,
  output logic              clear_evt,
  output logic [7:0]        feed_byte
);
  logic unused_wdata_bits;

  assign feed_evt          = wr && (addr == ADDR_DATA);
  assign clear_evt         = wr && (addr == ADDR_CTRL) && wdata[CLR_BIT];
  assign feed_byte         = wdata[7:0];
  assign unused_wdata_bits = ^wdata;

endmodule

// File: rtl/sir_crc_lfsr.sv
module sir_crc_lfsr
  import sir_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_evt,
  input  logic             feed_evt,
  input  logic [7:0]       feed_byte,
  output logic [CRC_W-1:0] crc_state
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear_evt) crc_state <= CRC_SEED;
    else if (feed_evt)       crc_state <= crc_fold_byte(crc_state, feed_byte);
  end

  AST_CRC_CLEAR_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (crc_state == CRC_SEED)); // R2
  AST_CRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_evt && !feed_evt) |=> $stable(crc_state)); // R9

endmodule

// File: rtl/sir_crc_byte_counter.sv
module sir_crc_byte_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_evt,
  input  logic             feed_evt,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_limit;
  assign at_limit = (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_evt)      count <= '0;
    else if (feed_evt && !at_limit) count <= count + 1'b1;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !clear_evt) |=> (count == CNT_MAX)); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_evt && !clear_evt && !at_limit) |=> (count == $past(count) + 1'b1)); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (count == '0)); // R2
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_evt && !clear_evt) |=> $stable(count)); // R9

endmodule

// File: rtl/sir_crc_engine.sv
module sir_crc_engine
  import sir_crc_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int ADDR_W  = 2,
  parameter int CLR_BIT = 15,
  parameter logic [ADDR_W-1:0] ADDR_CTRL   = 0,
  parameter logic [ADDR_W-1:0] ADDR_DATA   = 1,
  parameter logic [ADDR_W-1:0] ADDR_RESULT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata
);
  localparam int BUS_W = 16;
  localparam int PAD_W = BUS_W - CNT_W;

  logic              feed_evt;
  logic              clear_evt;
  logic [7:0]        feed_byte;
  logic [CRC_W-1:0]  crc_state;
  logic [CNT_W-1:0]  byte_count;

  sir_crc_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(BUS_W), .CLR_BIT(CLR_BIT),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_DATA(ADDR_DATA)
  ) u_decode (
    .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .feed_evt(feed_evt), .clear_evt(clear_evt), .feed_byte(feed_byte)
  );

  sir_crc_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt),
    .feed_evt(feed_evt), .feed_byte(feed_byte), .crc_state(crc_state)
  );

  sir_crc_byte_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt),
    .feed_evt(feed_evt), .count(byte_count)
  );

  always_comb begin
    if (bus_addr == ADDR_CTRL)        bus_rdata = {{PAD_W{1'b0}}, byte_count};
    else if (bus_addr == ADDR_RESULT) bus_rdata = ~crc_state;
    else                              bus_rdata = '0;
  end

  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CTRL) |-> (bus_rdata[BUS_W-1:CNT_W] == '0)); // R3
  AST_RESULT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_evt && !$isunknown(bus_addr)) |=> (crc_state == CRC_SEED)); // R2

endmodule

// File: tb/sir_crc_engine_test.sv
`timescale 1ns/1ps
module sir_crc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [15:0] m_crc;
  int          m_cnt;

  always #10 clk = ~clk;

  sir_crc_engine uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Byte-wide formula for the reflected CCITT checksum.
  function automatic logic [15:0] model_byte(input logic [15:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c[7:0] ^ b;
    x = x ^ (x << 4);
    return (c >> 8) ^ ({8'h00, x} << 8) ^ ({8'h00, x} << 3) ^ ({8'h00, x} >> 4);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic feed(input logic [15:0] d);
    bus_write(2'd1, d);
    m_crc = model_byte(m_crc, d[7:0]);
    if (m_cnt < 4095) m_cnt++;
  endtask

  task automatic soft_clear();
    bus_write(2'd0, 16'h8000);
    m_crc = 16'hFFFF;
    m_cnt = 0;
  endtask

  task automatic expect_state(input string tag);
    logic [15:0] v;
    bus_read(2'd0, v);
    check({tag, " count"}, v, m_cnt[15:0]);
    bus_read(2'd2, v);
    check({tag, " result"}, v, ~m_crc);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    m_crc = 16'hFFFF; m_cnt = 0;
    bus_read(2'd0, v); check("R1 count", v, 16'h0000);
    bus_read(2'd2, v); check("R1 result", v, 16'h0000);
  endtask

  task automatic t_known_answer();
    logic [15:0] v;
    soft_clear();
    feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
    bus_read(2'd0, v); check("R7 count", v, 16'd4);
    bus_read(2'd2, v); check("R7 result", v, 16'h51DF);
    check("R5 model agrees", ~m_crc, 16'h51DF);
  endtask

  task automatic t_patterns();
    soft_clear();
    for (int i = 0; i < 6; i++) begin
      feed(16'h0000);
      expect_state("R6 zeros");
    end
    soft_clear();
    for (int i = 0; i < 5; i++) feed(16'h00FF);
    expect_state("R5 ones");
    soft_clear();
    for (int i = 0; i < 20; i++) feed(16'(i * 37 + 5));
    expect_state("R5 ramp");
  endtask

  task automatic t_upper_ignored();
    soft_clear();
    feed(16'hAB12); feed(16'hFF34); feed(16'h5A56);
    expect_state("R4 upper bits");
  endtask

  task automatic t_clear_and_top();
    logic [15:0] v;
    soft_clear();
    feed(16'h0011); feed(16'h0022);
    bus_write(2'd0, 16'hFFFF);
    m_crc = 16'hFFFF; m_cnt = 0;
    expect_state("R2 clear");
    feed(16'h0033);
    bus_read(2'd0, v);
    check("R3 top bits", v & 16'hF000, 16'h0000);
  endtask

  task automatic t_no_effect();
    logic [15:0] v;
    soft_clear();
    feed(16'h0099); feed(16'h0042);
    bus_write(2'd0, 16'h7FFF);
    expect_state("R9 ctrl no clear");
    bus_write(2'd2, 16'h1234);
    expect_state("R9 result write");
    bus_write(2'd3, 16'h8000);
    expect_state("R9 unmapped write");
    bus_read(2'd3, v);
    check("R10 unmapped read", v, 16'h0000);
  endtask

  task automatic t_saturate();
    soft_clear();
    for (int i = 0; i < 4094; i++) feed(16'(i));
    expect_state("R8 below limit");
    feed(16'h0077);
    expect_state("R8 at limit");
    feed(16'h0088); feed(16'h0099);
    expect_state("R8 held");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known_answer();
    t_patterns();
    t_upper_ignored();
    t_clear_and_top();
    t_no_effect();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule